// File: doc/BRIEF.md
# Load-Shadow Selective Replay Tracker

This block sits beside an instruction scheduler that wakes dependents up speculatively, assuming every load hits. Between a load's issue and the cycle its hit/miss verdict is known, dependent instructions keep issuing. The tracker follows each issued instruction down a short pipeline of stage rows. Every row carries a dependence vector with one bit per load issue slot. A bit set in column i means the instruction depends, directly or through any chain of producers, on the load that currently holds slot i.

When the load in the verify stage is reported as a miss, the tracker raises a kill in that same cycle for every younger instruction whose vector holds the load's column. This covers the instruction issuing in that cycle as well as every instruction still in flight. For each killed instruction it presents the queue index, so that the scheduler can reissue it. The missing load itself is handed back as a reschedule request, and its column is freed. When the load hits, its column is simply cleared.

A mode input switches to non-selective recovery. In that mode a miss kills everything issued after the load, whether dependent or not. The scheduler issues at most one instruction per cycle and supplies the vectors of the two source producers. It also picks a free slot for each issuing load.

Top module: `lsr_tracker`

## Requirements
- R1: After a synchronous active-low reset, all stage rows are empty. No kill, completion or reschedule is signalled, even if `ld_miss` is high, until new instructions issue.
- R2: An instruction that issues in cycle n and is not killed appears on `done_valid`/`done_qidx` in cycle n+DEPTH, with its queue index.
- R3: A load that reaches the verify stage while `ld_miss` is low is reported complete. It raises no kill and no reschedule, and its dependents continue to completion.
- R4: The dependence vector of an issuing instruction is the bitwise OR of `iss_src_a` and `iss_src_b`, where bit i stands for load slot i. An issuing load also sets bit `iss_slot`. With `sel_mode`=1, a miss kills, in the same cycle, every younger instruction whose vector contains the missing load's slot bit.
- R5: Transitive dependents are killed in the same miss cycle. An example is an instruction whose producer depends on the missing load.
- R6: With `sel_mode`=1, a younger instruction whose vector lacks the missing load's bit is not killed and completes normally.
- R7: With `sel_mode`=0, a miss kills every valid instruction issued after the load: those in flight and the one issuing in the miss cycle.
- R8: A missing load raises `resched_valid` with its queue index and is not reported complete. Its slot is free for a new load from the next cycle.
- R9: A killed instruction never later appears on `done_valid`.
- R10: `stage_kill[0]` refers to the instruction at the issue port. `stage_kill[j]` for j>=1 refers to the instruction in stage row j-1, and a lower index means a younger instruction. `rq_qidx[j*QW +: QW]` holds the queue index for position j.
- R11: With several loads in flight, a miss affects only the dependents of the missing slot. A killed load releases its own slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_mode | input | 1 | 1 = selective replay, 0 = replay everything in the shadow |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_qidx | input | QW | Queue index of the issuing instruction |
| iss_is_load | input | 1 | The issuing instruction is a load |
| iss_slot | input | clog2(NSLOT) | Load slot assigned to an issuing load |
| iss_src_a | input | NSLOT | Dependence vector of the first source producer |
| iss_src_b | input | NSLOT | Dependence vector of the second source producer |
| ld_miss | input | 1 | Verdict for the load in the verify stage: 1 = miss |
| stage_kill | output | DEPTH | Kill per position (port, then stage rows) |
| rq_qidx | output | DEPTH*QW | Reissue queue index per kill position |
| done_valid | output | 1 | An instruction leaves the verify stage complete |
| done_qidx | output | QW | Its queue index |
| resched_valid | output | 1 | The verify-stage load missed and must be rescheduled |
| resched_qidx | output | QW | Queue index of the missing load |

## Verification
The collision that matters most is a miss verdict landing in the same cycle as a new issue. In that cycle the kill decision must cover the instruction at the port, whose vector is being formed from busy columns, and at the same time must free the column the port instruction may be reading. The bench provokes this in every swept case by issuing the third follower in the verify cycle, under every mix of independent, direct and chained dependences, both verdicts and both modes. It judges the kill bit and reissue index for all three positions against dependence flags it computes itself. A second directed case has two loads in flight and drops a load in non-selective mode. It then reuses that load's slot, so verification and release of a killed load's slot also collide in one cycle.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the load-shadow replay tracker.
// Assumes: nothing beyond standard SystemVerilog.
package lsr_pkg;

    // Recovery policy applied when a load in the verify stage misses
    typedef enum logic {
        RPL_ALL    = 1'b0,  // replay every instruction in the shadow
        RPL_SELECT = 1'b1   // replay only dependents of the missing slot
    } rpl_mode_e;

endpackage

// File: rtl/lsr_slot_track.sv
`timescale 1ns/1ps
// Module: lsr_slot_track
// Keeps one busy bit per load slot. A bit is set when a load is accepted
// into the tracker and cleared when the load is verified or killed.
// Assumes: the scheduler never hands out a slot that is still busy.
module lsr_slot_track #(
    parameter int NSLOT = 4,
    parameter int SW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [SW-1:0]    alloc_slot,
    input  logic [NSLOT-1:0] clr_mask,
    output logic [NSLOT-1:0] busy_q,
    output logic [NSLOT-1:0] live_now
);
    logic [NSLOT-1:0] alloc_mask;

    // Decode the slot being claimed this cycle
    always_comb alloc_mask = alloc_en ? (NSLOT'(1) << alloc_slot) : '0;

    // Slots still owned once this cycle's releases are applied
    assign live_now = busy_q & ~clr_mask;

    // Update ownership: releases first, then the new claim
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= live_now | alloc_mask;
    end

    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !live_now[alloc_slot]); // R8

    AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((busy_q & $past(clr_mask) & ~$past(alloc_mask)) == '0)); // R11
endmodule

// File: rtl/lsr_vec_merge.sv
`timescale 1ns/1ps
// Module: lsr_vec_merge
// Forms the dependence vector of the issuing instruction from the vectors
// of its two source producers. Stale bits of slots that are no longer
// owned are dropped. A load adds its own slot bit.
// vec_chk uses the ownership seen before this cycle's releases and drives
// the kill decision. vec_out uses the ownership after them and is stored.
module lsr_vec_merge #(
    parameter int NSLOT = 4,
    parameter int SW    = 2
) (
    input  logic [NSLOT-1:0] src_a,
    input  logic [NSLOT-1:0] src_b,
    input  logic [NSLOT-1:0] busy,
    input  logic [NSLOT-1:0] live,
    input  logic             is_load,
    input  logic [SW-1:0]    own_slot,
    output logic [NSLOT-1:0] vec_chk,
    output logic [NSLOT-1:0] vec_out
);
    logic [NSLOT-1:0] parents;
    logic [NSLOT-1:0] own_bit;

    // Union of the producers' dependences
    assign parents = src_a | src_b;
    // A load depends on itself for the benefit of its consumers
    assign own_bit = is_load ? (NSLOT'(1) << own_slot) : '0;
    // Vector tested against a verdict arriving this cycle
    assign vec_chk = parents & busy;
    // Vector written into the first stage row
    assign vec_out = (parents & live) | own_bit;
endmodule

// File: rtl/lsr_row.sv
`timescale 1ns/1ps
// Module: lsr_row
// One stage row of the dependence matrix: an instruction slot with its
// queue index, load flag, load slot and dependence vector. It captures
// the entry from the position above unless that entry is killed, and it
// clears released columns on the way.
// Assumes: in_kill is raised only for a present entry.
module lsr_row #(
    parameter int NSLOT = 4,
    parameter int SW    = 2,
    parameter int QW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_kill,
    input  logic [QW-1:0]    in_qidx,
    input  logic             in_load,
    input  logic [SW-1:0]    in_slot,
    input  logic [NSLOT-1:0] in_vec,
    input  logic [NSLOT-1:0] clr_mask,
    output logic             out_vld,
    output logic [QW-1:0]    out_qidx,
    output logic             out_load,
    output logic [SW-1:0]    out_slot,
    output logic [NSLOT-1:0] out_vec
);
    // Shift the entry down one stage, dropping killed entries and freed columns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_qidx <= '0;
            out_load <= 1'b0;
            out_slot <= '0;
            out_vec  <= '0;
        end else begin
            out_vld  <= in_vld & ~in_kill;
            out_qidx <= in_qidx;
            out_load <= in_load;
            out_slot <= in_slot;
            out_vec  <= in_vec & ~clr_mask;
        end
    end

    AST_KILL_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_kill |-> in_vld); // R10

    AST_KILLED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        in_kill |=> !out_vld); // R9
endmodule

// File: rtl/lsr_tracker.sv
`timescale 1ns/1ps
// Module: lsr_tracker (top)
// Load-shadow replay tracker. DEPTH stage rows separate issue from load
// verification. Kill position 0 is the issue port and position j is
// row j-1. On a miss at the verify stage, every position whose
// dependence vector holds the missing slot is killed in the same cycle
// (or every valid position in non-selective mode). The missing load is
// returned for rescheduling, and the slots of verified or killed loads
// are released.
// Assumes: one issue per cycle, DEPTH >= 2, NSLOT >= 2, and the
// scheduler assigns only free slots.
module lsr_tracker import lsr_pkg::*; #(
    parameter int NSLOT = 4,
    parameter int DEPTH = 3,
    parameter int QW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_mode,
    input  logic                  iss_valid,
    input  logic [QW-1:0]         iss_qidx,
    input  logic                  iss_is_load,
    input  logic [$clog2(NSLOT)-1:0] iss_slot,
    input  logic [NSLOT-1:0]      iss_src_a,
    input  logic [NSLOT-1:0]      iss_src_b,
    input  logic                  ld_miss,
    output logic [DEPTH-1:0]      stage_kill,
    output logic [DEPTH*QW-1:0]   rq_qidx,
    output logic                  done_valid,
    output logic [QW-1:0]         done_qidx,
    output logic                  resched_valid,
    output logic [QW-1:0]         resched_qidx
);
    localparam int SW   = $clog2(NSLOT);
    localparam int LAST = DEPTH - 1;

    rpl_mode_e mode;
    assign mode = rpl_mode_e'(sel_mode);

    // Kill-candidate positions: 0 = issue port, j = stage row j-1
    logic             c_vld  [DEPTH];
    logic [QW-1:0]    c_qidx [DEPTH];
    logic             c_load [DEPTH];
    logic [SW-1:0]    c_slot [DEPTH];
    logic [NSLOT-1:0] c_vec  [DEPTH];
    logic [NSLOT-1:0] chk_vec[DEPTH];
    logic [NSLOT-1:0] free_mask[DEPTH];

    // Verify stage (output of the last row)
    logic             v_vld, v_load;
    logic [QW-1:0]    v_qidx;
    logic [SW-1:0]    v_slot;
    logic [NSLOT-1:0] v_vec;

    logic             vfy_now, miss_now;
    logic [NSLOT-1:0] vfy_mask, clr_mask;
    logic [NSLOT-1:0] busy_q, live_now;
    logic [NSLOT-1:0] port_chk, port_vec;
    logic             alloc_en;

    // Verdict decode for the load at the verify stage
    assign vfy_now  = v_vld & v_load;
    assign miss_now = vfy_now & ld_miss;
    assign vfy_mask = vfy_now ? (NSLOT'(1) << v_slot) : '0;

    // Columns released this cycle: verified load plus any killed loads
    always_comb begin
        clr_mask = vfy_mask;
        for (int j = 0; j < DEPTH; j++) clr_mask = clr_mask | free_mask[j];
    end

    // A load holds its slot only if it enters the rows
    assign alloc_en = iss_valid & iss_is_load & ~stage_kill[0];

    lsr_slot_track #(.NSLOT(NSLOT), .SW(SW)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_slot(iss_slot),
        .clr_mask(clr_mask), .busy_q(busy_q), .live_now(live_now)
    );

    lsr_vec_merge #(.NSLOT(NSLOT), .SW(SW)) u_merge (
        .src_a(iss_src_a), .src_b(iss_src_b),
        .busy(busy_q), .live(live_now),
        .is_load(iss_is_load), .own_slot(iss_slot),
        .vec_chk(port_chk), .vec_out(port_vec)
    );

    // Issue port occupies candidate position 0
    assign c_vld[0]   = iss_valid;
    assign c_qidx[0]  = iss_qidx;
    assign c_load[0]  = iss_is_load;
    assign c_slot[0]  = iss_slot;
    assign c_vec[0]   = port_vec;
    assign chk_vec[0] = port_chk;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_pos
            // Kill decision for this position under the selected policy
            assign stage_kill[g] = miss_now & c_vld[g] &
                                   ((mode == RPL_ALL) | (|(chk_vec[g] & vfy_mask)));
            assign rq_qidx[g*QW +: QW] = c_qidx[g];

            if (g == 0) begin : g_port
                // A load at the port has not claimed its slot yet
                assign free_mask[g] = '0;
            end else begin : g_inrow
                // Row contents are tested as stored
                assign chk_vec[g]   = c_vec[g];
                assign free_mask[g] = (stage_kill[g] & c_load[g]) ?
                                      (NSLOT'(1) << c_slot[g]) : '0;
            end

            if (g < LAST) begin : g_mid
                lsr_row #(.NSLOT(NSLOT), .SW(SW), .QW(QW)) u_row (
                    .clk(clk), .rst_n(rst_n),
                    .in_vld(c_vld[g]), .in_kill(stage_kill[g]),
                    .in_qidx(c_qidx[g]), .in_load(c_load[g]),
                    .in_slot(c_slot[g]), .in_vec(c_vec[g]),
                    .clr_mask(clr_mask),
                    .out_vld(c_vld[g+1]), .out_qidx(c_qidx[g+1]),
                    .out_load(c_load[g+1]), .out_slot(c_slot[g+1]),
                    .out_vec(c_vec[g+1])
                );
            end else begin : g_end
                lsr_row #(.NSLOT(NSLOT), .SW(SW), .QW(QW)) u_row (
                    .clk(clk), .rst_n(rst_n),
                    .in_vld(c_vld[g]), .in_kill(stage_kill[g]),
                    .in_qidx(c_qidx[g]), .in_load(c_load[g]),
                    .in_slot(c_slot[g]), .in_vec(c_vec[g]),
                    .clr_mask(clr_mask),
                    .out_vld(v_vld), .out_qidx(v_qidx),
                    .out_load(v_load), .out_slot(v_slot),
                    .out_vec(v_vec)
                );
            end
        end
    endgenerate

    // Leaving the verify stage: complete, or hand the missing load back
    assign done_valid    = v_vld & ~miss_now;
    assign done_qidx     = v_qidx;
    assign resched_valid = miss_now;
    assign resched_qidx  = v_qidx;

    AST_VERIFY_OWN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_now |-> v_vec[v_slot]); // R4

    AST_NONSEL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_now && !sel_mode && c_vld[1]) |-> stage_kill[1]); // R7

    AST_MISS_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        resched_valid |=> !(done_valid && done_qidx == $past(resched_qidx) && !$past(iss_valid))); // R8
endmodule

// File: tb/sim_lsr_tracker.sv
`timescale 1ns/1ps
// Bench: sweeps dependence patterns, verdicts and modes over the default
// configuration (4 slots, 3 stages, 4-bit queue index).
module sim_lsr_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_mode = 1'b1;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_qidx = '0;
    logic        iss_is_load = 1'b0;
    logic [1:0]  iss_slot = '0;
    logic [3:0]  iss_src_a = '0;
    logic [3:0]  iss_src_b = '0;
    logic        ld_miss = 1'b0;
    logic [2:0]  stage_kill;
    logic [11:0] rq_qidx;
    logic        done_valid;
    logic [3:0]  done_qidx;
    logic        resched_valid;
    logic [3:0]  resched_qidx;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    lsr_tracker #(.NSLOT(4), .DEPTH(3), .QW(4)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_mode(sel_mode),
        .iss_valid(iss_valid), .iss_qidx(iss_qidx), .iss_is_load(iss_is_load),
        .iss_slot(iss_slot), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .ld_miss(ld_miss), .stage_kill(stage_kill), .rq_qidx(rq_qidx),
        .done_valid(done_valid), .done_qidx(done_qidx),
        .resched_valid(resched_valid), .resched_qidx(resched_qidx)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge and drive one issue slot
    task automatic cyc(input bit v, input bit [3:0] q, input bit ld, input bit [1:0] sl,
                       input bit [3:0] a, input bit [3:0] b, input bit miss);
        @(negedge clk);
        iss_valid = v; iss_qidx = q; iss_is_load = ld; iss_slot = sl;
        iss_src_a = a; iss_src_b = b; ld_miss = miss;
        #1;
    endtask

    task automatic idle(input bit miss);
        cyc(1'b0, 4'd0, 1'b0, 2'd0, 4'd0, 4'd0, miss);
    endtask

    // Load in cycle 0, followers in cycles 1..3, verdict in cycle 3
    task automatic run_case(input bit sel, input bit miss, input int pat, input int slot);
        int         code[3];
        bit         dep[3];
        bit         kb[3];
        bit [3:0]   va[3];
        bit [3:0]   vb[3];
        bit [3:0]   lv, nz, prv;
        bit         dprev;
        string      tag;
        lv = 4'b1 << slot;
        nz = 4'b1 << ((slot + 1) % 4);
        prv = lv; dprev = 1'b1;
        code[0] = pat % 3; code[1] = (pat / 3) % 3; code[2] = pat / 9;
        for (int k = 0; k < 3; k++) begin
            case (code[k])
                0: begin va[k] = 4'd0; vb[k] = 4'd0; dep[k] = 1'b0; prv = 4'd0; end
                1: begin va[k] = lv;   vb[k] = 4'd0; dep[k] = 1'b1; prv = lv;   end
                default: begin va[k] = nz; vb[k] = prv; dep[k] = dprev; end
            endcase
            dprev = dep[k];
            kb[k] = miss && (!sel || dep[k]);
        end
        sel_mode = sel;
        cyc(1'b1, 4'd1, 1'b1, 2'(slot), 4'd0, 4'd0, 1'b0);
        chk("R10", "kill while no verdict", stage_kill, 0);
        cyc(1'b1, 4'd2, 1'b0, 2'd0, va[0], vb[0], 1'b0);
        cyc(1'b1, 4'd3, 1'b0, 2'd0, va[1], vb[1], 1'b0);
        chk("R2", "done before verify", done_valid, 0);
        cyc(1'b1, 4'd4, 1'b0, 2'd0, va[2], vb[2], miss);
        for (int k = 0; k < 3; k++) begin
            if (!sel)                        tag = "R7";
            else if (!dep[k])                tag = "R6";
            else if (code[k] == 2 && k > 0)  tag = "R5";
            else                             tag = "R4";
            chk(tag, $sformatf("kill bit %0d", 2 - k), stage_kill[2-k], kb[k]);
            if (kb[k])
                chk("R10", $sformatf("reissue index %0d", 2 - k),
                    rq_qidx[(2-k)*4 +: 4], k + 2);
        end
        chk("R8", "resched_valid", resched_valid, miss);
        if (miss) chk("R8", "resched_qidx", resched_qidx, 1);
        chk("R3", "load done_valid", done_valid, !miss);
        if (!miss) chk("R3", "load done_qidx", done_qidx, 1);
        for (int k = 0; k < 3; k++) begin
            idle(1'b0);
            chk(kb[k] ? "R9" : "R2", $sformatf("follower %0d done_valid", k + 1),
                done_valid, !kb[k]);
            if (!kb[k]) chk("R2", $sformatf("follower %0d done_qidx", k + 1), done_qidx, k + 2);
            chk("R10", "kill after verdict", stage_kill, 0);
        end
        idle(1'b0);
        chk("R2", "pipeline drained", done_valid, 0);
    endtask

    // Two loads in flight; the older one misses
    task automatic run_two_loads(input bit sel);
        sel_mode = sel;
        cyc(1'b1, 4'd5, 1'b1, 2'd1, 4'd0, 4'd0, 1'b0);
        cyc(1'b1, 4'd6, 1'b1, 2'd2, 4'd0, 4'd0, 1'b0);
        cyc(1'b1, 4'd7, 1'b0, 2'd0, 4'b0100, 4'd0, 1'b0);
        cyc(1'b1, 4'd8, 1'b0, 2'd0, 4'b0010, 4'd0, 1'b1);
        chk(sel ? "R11" : "R7", "two-load kill vector", stage_kill, sel ? 3'b001 : 3'b111);
        chk("R8", "two-load resched_qidx", resched_qidx, 5);
        // Second load's slot reused right away in non-selective mode
        cyc(!sel, 4'd9, 1'b1, 2'd2, 4'd0, 4'd0, 1'b0);
        chk("R11", "second load done_valid", done_valid, sel);
        if (sel) chk("R11", "second load done_qidx", done_qidx, 6);
        idle(1'b0);
        chk("R11", "independent consumer done", done_valid, sel);
        if (sel) chk("R11", "independent consumer qidx", done_qidx, 7);
        idle(1'b0);
        chk("R9", "killed dependent not done", done_valid, 0);
        idle(1'b0);
        chk("R11", "reused slot load done", done_valid, !sel);
        if (!sel) chk("R11", "reused slot load qidx", done_qidx, 9);
        idle(1'b0);
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1'b1);
        chk("R1", "kill after reset", stage_kill, 0);
        chk("R1", "done after reset", done_valid, 0);
        chk("R1", "resched after reset", resched_valid, 0);
        idle(1'b0);

        // Reset in flight discards all rows
        sel_mode = 1'b1;
        cyc(1'b1, 4'd1, 1'b1, 2'd0, 4'd0, 4'd0, 1'b0);
        cyc(1'b1, 4'd2, 1'b0, 2'd0, 4'b0001, 4'd0, 1'b0);
        rst_n = 1'b0;
        idle(1'b0);
        rst_n = 1'b1;
        idle(1'b1);
        chk("R1", "kill after mid-run reset", stage_kill, 0);
        chk("R1", "resched after mid-run reset", resched_valid, 0);
        chk("R1", "done after mid-run reset", done_valid, 0);
        idle(1'b1);
        chk("R1", "done second cycle after reset", done_valid, 0);
        idle(1'b0);

        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 2; m++)
                for (int p = 0; p < 27; p++)
                    run_case(s[0], m[0], p, (p + 2 * s + m) % 4);

        // Missing load reissued into its own slot the next cycle
        sel_mode = 1'b1;
        cyc(1'b1, 4'd9, 1'b1, 2'd3, 4'd0, 4'd0, 1'b0);
        idle(1'b0);
        idle(1'b0);
        idle(1'b1);
        chk("R8", "first attempt resched", resched_valid, 1);
        chk("R8", "first attempt not done", done_valid, 0);
        cyc(1'b1, 4'd9, 1'b1, 2'd3, 4'd0, 4'd0, 1'b0);
        idle(1'b0);
        idle(1'b0);
        idle(1'b0);
        chk("R8", "reissued load done", done_valid, 1);
        chk("R8", "reissued load qidx", done_qidx, 9);
        idle(1'b0);

        run_two_loads(1'b1);
        run_two_loads(1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule